// File: doc/BRIEF.md
# Saturating Arithmetic Unit

A 32-bit datapath block that performs clamping arithmetic for a processor execution pipe. One operation is accepted per cycle when `in_valid` is high; the operation code selects signed or unsigned saturating add or subtract, a plain wrapping add that still watches for signed overflow, or a saturate-to-a-chosen-bit-position operation applied either to the whole word or to two independent 16-bit halves.

Whenever an operation has to clamp its result, a single sticky flag (`q_flag`) is raised. No arithmetic operation ever lowers it. Only the explicit `q_clear` strobe lowers it, and the strobe wins over a set in the same cycle. Results are registered and appear one cycle after the accepted strobe, together with `res_valid`.

Top module: `sat_alu_top`

## Requirements
- R1: Op code 0 is a signed saturating add. Overflow occurs when both operands have the same sign and the sum's sign differs from `opnd_a`. On overflow the result is 0x7FFFFFFF if `opnd_a` is non-negative and 0x80000000 otherwise.
- R2: Op code 1 is a signed saturating subtract `opnd_a - opnd_b`. Overflow occurs when the operand signs differ and the difference's sign differs from `opnd_a`. It clamps the same way as R1.
- R3: Op code 2 is an unsigned add that clamps to 0xFFFFFFFF on a carry out. Op code 3 is an unsigned subtract that clamps to 0 on a borrow.
- R4: Op code 4 returns the modular 32-bit sum and counts a signed add overflow as a clamp event for `q_flag`.
- R5: Op code 5 saturates signed `opnd_a` to the range -2^n .. 2^n-1, where n = `sat_pos`. Values above the range give 2^n-1; values below it give the bitwise complement of 2^n-1.
- R6: Op code 6 saturates `opnd_a` as unsigned. A negative input (bit 31 set) gives 0, and an input above 2^n-1 gives 2^n-1.
- R7: Op codes 7 (signed) and 8 (unsigned) apply R5 and R6 to each sign-extended 16-bit half of `opnd_a` independently. The low half's result is placed in bits 15:0 and the high half's result in bits 31:16. A clamp in either half counts as a clamp event.
- R8: Every clamp event of an accepted operation sets `q_flag` in the same cycle the result appears. `q_flag` stays set through any later operations and through idle cycles.
- R9: `q_clear` forces `q_flag` to 0 on the next edge, even when the operation accepted in that cycle clamps.
- R10: `res_out` and `res_valid` update one clock edge after an accepted operation. While `in_valid` is low, `res_valid` falls, `res_out` holds its value and `q_flag` is not set.
- R11: Op codes 9 to 15 return `opnd_a` unchanged and leave `q_flag` as it was.
- R12: Synchronous active-high `rst` clears `res_out`, `res_valid` and `q_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 4 | Operation code (see R1 to R11) |
| opnd_a | input | 32 | First operand / value to saturate |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_pos | input | 5 | Saturation bit position n |
| q_clear | input | 1 | Clear the sticky flag |
| res_out | output | 32 | Registered result |
| res_valid | output | 1 | Result produced by the previous cycle's operation |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with its default 32-bit word, two 16-bit lanes and a 5-bit position field. With these values every position from 0 to 31 can be reached. That includes positions of 16 and above, where a half-word lane can no longer clamp in signed mode and can clamp only negative values in unsigned mode. Operands are drawn from sign-boundary corner values mixed with random words, so every overflow rule fires in both directions. The clear strobe is pulsed at random, including in cycles where a clamp happens at the same time.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int DW     = 32;
    localparam int LANE_W = 16;
    localparam int NLANE  = DW / LANE_W;
    localparam int POS_W  = $clog2(DW);
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_UADD  = 4'd2,
        OP_USUB  = 4'd3,
        OP_WADD  = 4'd4,
        OP_SSATN = 4'd5,
        OP_USATN = 4'd6,
        OP_SSAT2 = 4'd7,
        OP_USAT2 = 4'd8
    } sat_op_e;

    typedef struct packed {
        logic [DW-1:0] val;
        logic          hit;
    } sat_res_t;

    function automatic logic [DW-1:0] signed_rail(input logic neg);
        return {neg, {(DW-1){~neg}}};
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output sat_res_t      s_add,
    output sat_res_t      s_sub,
    output sat_res_t      u_add,
    output sat_res_t      u_sub,
    output sat_res_t      w_add
);
    logic [DW:0] sum_x;
    logic [DW:0] dif_x;
    logic        ovf_add;
    logic        ovf_sub;

    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};

    assign ovf_add = (a[DW-1] == b[DW-1]) && (sum_x[DW-1] != a[DW-1]);
    assign ovf_sub = (a[DW-1] != b[DW-1]) && (dif_x[DW-1] != a[DW-1]);

    always_comb begin
        s_add.hit = ovf_add;
        s_add.val = ovf_add ? signed_rail(a[DW-1]) : sum_x[DW-1:0];

        s_sub.hit = ovf_sub;
        s_sub.val = ovf_sub ? signed_rail(a[DW-1]) : dif_x[DW-1:0];

        u_add.hit = sum_x[DW];
        u_add.val = sum_x[DW] ? {DW{1'b1}} : sum_x[DW-1:0];

        u_sub.hit = dif_x[DW];
        u_sub.val = dif_x[DW] ? '0 : dif_x[DW-1:0];

        w_add.hit = ovf_add;
        w_add.val = sum_x[DW-1:0];
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
#(
    parameter int LW = DW
) (
    input  logic signed [LW-1:0]    val,
    input  logic        [POS_W-1:0] pos,
    input  logic                    uns,
    output logic        [LW-1:0]    res,
    output logic                    hit
);
    logic signed [DW-1:0] ext;
    logic signed [DW-1:0] upper;
    logic                 neg;
    logic                 above;
    logic                 below;

    assign ext   = DW'(val);
    assign upper = ext >>> pos;
    assign neg   = ext[DW-1];

    always_comb begin
        above = !neg && (upper != '0);
        below = uns ? neg : (neg && (upper != '1));
        hit   = above || below;
        if (above)
            res = LW'((DW'(1) << pos) - DW'(1));
        else if (below)
            res = uns ? '0 : LW'(~((DW'(1) << pos) - DW'(1)));
        else
            res = val;
    end
endmodule

// File: rtl/sat_alu_top.sv
module sat_alu_top
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_sel,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [POS_W-1:0] sat_pos,
    input  logic             q_clear,
    output logic [DW-1:0]    res_out,
    output logic             res_valid,
    output logic             q_flag
);
    sat_res_t r_sadd, r_ssub, r_uadd, r_usub, r_wadd;
    sat_res_t r_word, r_lanes, nxt;

    logic             lane_uns;
    logic [NLANE-1:0] lane_hit;
    logic [DW-1:0]    lane_word;

    sat_addsub u_arith (
        .a     (opnd_a),
        .b     (opnd_b),
        .s_add (r_sadd),
        .s_sub (r_ssub),
        .u_add (r_uadd),
        .u_sub (r_usub),
        .w_add (r_wadd)
    );

    sat_clamp #(.LW(DW)) u_word (
        .val (opnd_a),
        .pos (sat_pos),
        .uns (op_sel == OP_USATN),
        .res (r_word.val),
        .hit (r_word.hit)
    );

    assign lane_uns = (op_sel == OP_USAT2);

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        sat_clamp #(.LW(LANE_W)) u_lane (
            .val (opnd_a[gi*LANE_W +: LANE_W]),
            .pos (sat_pos),
            .uns (lane_uns),
            .res (lane_word[gi*LANE_W +: LANE_W]),
            .hit (lane_hit[gi])
        );
    end

    assign r_lanes.val = lane_word;
    assign r_lanes.hit = |lane_hit;

    always_comb begin
        case (op_sel)
            OP_SADD:           nxt = r_sadd;
            OP_SSUB:           nxt = r_ssub;
            OP_UADD:           nxt = r_uadd;
            OP_USUB:           nxt = r_usub;
            OP_WADD:           nxt = r_wadd;
            OP_SSATN,
            OP_USATN:          nxt = r_word;
            OP_SSAT2,
            OP_USAT2:          nxt = r_lanes;
            default: begin
                nxt.val = opnd_a;
                nxt.hit = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out   <= '0;
            res_valid <= 1'b0;
            q_flag    <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                res_out <= nxt.val;
            if (q_clear)
                q_flag <= 1'b0;
            else if (in_valid && nxt.hit)
                q_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
    import sat_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_sel,
    input logic [DW-1:0]    opnd_a,
    input logic [DW-1:0]    opnd_b,
    input logic             q_clear,
    input logic [DW-1:0]    res_out,
    input logic             res_valid,
    input logic             q_flag
);
    assert_sadd_no_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_SADD && !opnd_a[DW-1] && !opnd_b[DW-1]) |=> !res_out[DW-1]);

    assert_uadd_floor_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_UADD) |=> (res_out >= $past(opnd_a)));

    assert_usub_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == OP_USUB) |=> (res_out <= $past(opnd_a)));

    assert_q_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (q_flag && !q_clear) |=> q_flag);

    assert_q_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
        q_clear |=> !q_flag);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res_out) && !$rose(q_flag)));

    assert_unused_pass_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel > OP_USAT2 && !q_clear) |=>
            (res_out == $past(opnd_a) && $stable(q_flag)));
endmodule

bind sat_alu_top sat_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .q_clear   (q_clear),
    .res_out   (res_out),
    .res_valid (res_valid),
    .q_flag    (q_flag)
);

// File: tb/tb_sat_alu_top.sv
module tb_sat_alu_top;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op_sel;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  sat_pos;
    logic        q_clear;
    logic [31:0] res_out;
    logic        res_valid;
    logic        q_flag;

    int n_vec = 0;
    int n_bad = 0;
    bit q_exp = 1'b0;
    logic [31:0] last_res = '0;

    always #(CLK_PER/2) clk = ~clk;

    sat_alu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos),
        .q_clear(q_clear), .res_out(res_out), .res_valid(res_valid),
        .q_flag(q_flag)
    );

    function automatic longint clamp_n(longint v, int n, bit uns, output bit hit);
        longint hi = (64'sd1 <<< n) - 1;
        longint lo = uns ? 64'sd0 : -(64'sd1 <<< n);
        hit = 1'b0;
        if (v > hi) begin hit = 1'b1; return hi; end
        if (v < lo) begin hit = 1'b1; return lo; end
        return v;
    endfunction

    function automatic logic [32:0] model(logic [3:0] op, logic [31:0] a,
                                          logic [31:0] b, logic [4:0] n);
        longint s, u, v0, v1;
        bit h0, h1;
        longint smax = 64'sd2147483647;
        longint smin = -64'sd2147483648;
        case (op)
            4'd0, 4'd4: begin
                s = longint'($signed(a)) + longint'($signed(b));
                if (op == 4'd4) return {(s > smax || s < smin), a + b};
                if (s > smax) return {1'b1, 32'h7FFFFFFF};
                if (s < smin) return {1'b1, 32'h80000000};
                return {1'b0, s[31:0]};
            end
            4'd1: begin
                s = longint'($signed(a)) - longint'($signed(b));
                if (s > smax) return {1'b1, 32'h7FFFFFFF};
                if (s < smin) return {1'b1, 32'h80000000};
                return {1'b0, s[31:0]};
            end
            4'd2: begin
                u = longint'(a) + longint'(b);
                if (u > 64'sh0FFFFFFFF) return {1'b1, 32'hFFFFFFFF};
                return {1'b0, u[31:0]};
            end
            4'd3: begin
                u = longint'(a) - longint'(b);
                if (u < 0) return {1'b1, 32'h0};
                return {1'b0, u[31:0]};
            end
            4'd5, 4'd6: begin
                v0 = clamp_n(longint'($signed(a)), int'(n), op == 4'd6, h0);
                return {h0, v0[31:0]};
            end
            4'd7, 4'd8: begin
                v0 = clamp_n(longint'($signed(a[15:0])), int'(n), op == 4'd8, h0);
                v1 = clamp_n(longint'($signed(a[31:16])), int'(n), op == 4'd8, h1);
                return {h0 | h1, v1[15:0], v0[15:0]};
            end
            default: return {1'b0, a};
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h0;
            1: return 32'h7FFFFFFF;
            2: return 32'h80000000;
            3: return 32'hFFFFFFFF;
            4: return 32'h1 + ($urandom % 4);
            5: return {16'h0, 16'h7FFF ^ 16'($urandom % 4)};
            6: return {{16{1'b1}}, 16'($urandom)};
            default: return $urandom;
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller is at a negedge; drives one op, checks at the following negedge.
    task automatic apply(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic [4:0] n, bit clr);
        logic [32:0] exp;
        string qtag;
        exp = model(op, a, b, n);
        in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
        sat_pos = n; q_clear = clr;
        qtag = clr ? "R9" : "R8";
        if (clr) q_exp = 1'b0;
        else if (exp[32]) q_exp = 1'b1;
        @(negedge clk);
        check(res_out == exp[31:0], tag_of(op), {1'b0, res_out}, {1'b0, exp[31:0]});
        check(q_flag == q_exp, qtag, {32'h0, q_flag}, {32'h0, q_exp});
        check(res_valid == 1'b1, "R10", {32'h0, res_valid}, 33'h1);
        last_res = exp[31:0];
    endtask

    task automatic idle_cycle(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        in_valid = 1'b0; op_sel = op; opnd_a = a; opnd_b = b; q_clear = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R10", {32'h0, res_valid}, 33'h0);
        check(res_out == last_res, "R10", {1'b0, res_out}, {1'b0, last_res});
        check(q_flag == q_exp, "R10", {32'h0, q_flag}, {32'h0, q_exp});
    endtask

    initial begin
        #(CLK_PER * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        sat_pos = '0; q_clear = 1'b0;
        repeat (3) @(negedge clk);
        check(res_out == 0 && res_valid == 0 && q_flag == 0, "R12",
              {res_valid, res_out}, 33'h0);
        rst = 1'b0;

        // Directed corner cases
        apply(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);          // R1 positive clamp
        apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b1);                 // R9 clear
        apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0);   // R1 negative clamp
        apply(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1);          // R9 clear beats set
        apply(4'd1, 32'h80000000, 32'h1, 5'd0, 1'b0);          // R2 negative clamp
        apply(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b1);   // R2 positive, cleared
        apply(4'd2, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b1);          // R3 carry
        apply(4'd3, 32'h1, 32'h2, 5'd0, 1'b1);                 // R3 borrow
        apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        apply(4'd4, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);          // R4 wraps, sets Q
        apply(4'd2, 32'h1, 32'h1, 5'd0, 1'b0);                 // R8 Q stays
        apply(4'd5, 32'h00000100, 32'h0, 5'd7, 1'b1);          // R5 above
        apply(4'd5, 32'hFFFFFF00, 32'h0, 5'd7, 1'b1);          // R5 below
        apply(4'd5, 32'h80000000, 32'h0, 5'd31, 1'b1);         // R5 full range
        apply(4'd6, 32'hFFFFFFFF, 32'h0, 5'd4, 1'b1);          // R6 negative
        apply(4'd6, 32'h7FFFFFFF, 32'h0, 5'd31, 1'b1);         // R6 n=31
        apply(4'd7, 32'h8000_7FFF, 32'h0, 5'd3, 1'b1);         // R7 signed lanes
        apply(4'd8, 32'h0005_FFFF, 32'h0, 5'd2, 1'b1);         // R7 unsigned lanes
        apply(4'd8, 32'h7FFF_8000, 32'h0, 5'd20, 1'b1);        // R7 n >= 16
        apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        apply(4'd12, 32'hDEADBEEF, 32'h12345678, 5'd0, 1'b0);  // R11 Q stays 0
        apply(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0);
        apply(4'd15, 32'h00000001, 32'h7FFFFFFF, 5'd0, 1'b0);  // R11 Q stays 1
        idle_cycle(4'd0, 32'h7FFFFFFF, 32'h1);                 // R10 idle
        apply(4'd0, 32'h0, 32'h0, 5'd0, 1'b1);
        idle_cycle(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);          // R10 no Q set

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            op = ($urandom % 10 == 0) ? 4'(9 + $urandom % 7) : 4'($urandom % 9);
            if ($urandom % 16 == 0)
                idle_cycle(op, pick(), pick());
            else
                apply(op, pick(), pick(), 5'($urandom), ($urandom % 8) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule